// File: doc/BRIEF.md
# Free-Region Block Allocator

This block keeps a small table of free memory regions. Each region is a base address and a size, and the table is kept in increasing base order. An allocation request carries a size and a placement policy: first fit, best fit or worst fit. The block walks the table one entry per clock and picks a region. It grants the low end of that region and cuts the exact requested amount from it, so no allocation is rounded up. A region that is used up leaves the table, and the entries behind it close the gap.

A release request puts a region back into the table at its place in address order. Neighbouring regions are not merged. A request can fail in three ways: no single region is large enough (even when the total free space is), the table is full on a release, or the size is zero. One cycle-long done pulse ends every accepted request and carries the status and the granted base.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A requester that sees `req_ready` low must hold its request fields steady until the transfer happens. The response side has no back-pressure: the done pulse lasts exactly one cycle.

Top module: `fl_alloc`

## Requirements
- R1: With policy code 0 (first fit; code 3 acts the same), the grant comes from the lowest-address region whose size is at least the request.
- R2: With policy code 1 (best fit), the grant comes from the smallest region whose size is at least the request. Among equal sizes, the lower address wins.
- R3: With policy code 2 (worst fit), the grant comes from the largest region, with the lower address winning a tie. If that region is smaller than the request, the result is no fit.
- R4: A grant returns the chosen region's base with status 0. A larger region keeps the remainder: its base moves up by the request and its size shrinks by the request.
- R5: A region whose size equals the request is removed whole. The regions at higher addresses move up one slot, and the order is kept.
- R6: When no single region can hold the request, the status is 1, the base is 0, and the table is left unchanged.
- R7: A release (`req_op`=1) inserts its region after every region whose base is less than or equal to its base, and answers status 0. When the table already holds N_ENTRIES regions, the status is 2 and the table is left unchanged.
- R8: A request of either kind with size 0 answers status 3 and leaves the table unchanged.
- R9: `req_ready` is high exactly while idle and drops in the cycle after an acceptance. Every accepted request gets exactly one single-cycle done pulse. `req_ready` is already high in the cycle of that pulse, so the next request can be accepted at that very edge.
- R10: After reset the table is empty, `req_ready` is high and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 1 | 0 allocate, 1 release |
| req_policy | input | 2 | 0 first fit, 1 best fit, 2 worst fit, 3 as first fit |
| req_size | input | SIZE_W | Amount to allocate or release |
| req_base | input | ADDR_W | Base of a released region (ignored on allocate) |
| rsp_done | output | 1 | One-cycle pulse ending a request |
| rsp_status | output | 2 | 0 ok, 1 no fit, 2 table full, 3 zero size |
| rsp_base | output | ADDR_W | Granted base, 0 when nothing is granted |

## Verification
Two things can happen in the same cycle: the done pulse that ends one request, and the handshake that accepts the next. The bench provokes this by keeping `req_valid` high through the done cycle and changing the request fields in that cycle. It then checks three things: `req_ready` is high alongside the pulse, the new request is taken at the following edge, and its result matches a model that has already applied the first request's change to the table. A sweep of several hundred mixed requests with all policies, run on a four-entry table, also produces grants that empty a region and releases that meet a full table.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [1:0] {
    FIT_FIRST = 2'd0,
    FIT_BEST  = 2'd1,
    FIT_WORST = 2'd2,
    FIT_SPARE = 2'd3
  } fit_e;

  typedef enum logic [1:0] {
    RS_OK    = 2'd0,
    RS_NOFIT = 2'd1,
    RS_FULL  = 2'd2,
    RS_BADSZ = 2'd3
  } rstat_e;

  typedef enum logic [1:0] {
    TC_NONE = 2'd0,
    TC_TRIM = 2'd1,
    TC_DROP = 2'd2,
    TC_ADD  = 2'd3
  } tcmd_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_SCAN = 2'd1,
    CS_FIN  = 2'd2
  } cstate_e;
endpackage

// File: rtl/fl_table.sv
module fl_table
  import fl_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 16,
  localparam int IW       = $clog2(N_ENTRIES + 1),
  localparam int AIW      = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tcmd_e             cmd,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [IW-1:0]     rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [SIZE_W-1:0] rd_size,
  output logic [IW-1:0]     count
);
  logic [ADDR_W-1:0] base_v [N_ENTRIES];
  logic [SIZE_W-1:0] size_v [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : slot
    logic [ADDR_W-1:0] b_q, up_b, dn_b;
    logic [SIZE_W-1:0] s_q, up_s, dn_s;

    if (g < N_ENTRIES - 1) begin : g_up
      assign up_b = base_v[g+1];
      assign up_s = size_v[g+1];
    end else begin : g_top
      assign up_b = '0;
      assign up_s = '0;
    end

    if (g > 0) begin : g_dn
      assign dn_b = base_v[g-1];
      assign dn_s = size_v[g-1];
    end else begin : g_bot
      assign dn_b = '0;
      assign dn_s = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '0;
        s_q <= '0;
      end else begin
        case (cmd)
          TC_TRIM: if (cmd_idx == IW'(g)) begin
            b_q <= b_q + ADDR_W'(cmd_size);
            s_q <= s_q - cmd_size;
          end
          TC_DROP: if (cmd_idx <= IW'(g)) begin
            b_q <= up_b;
            s_q <= up_s;
          end
          TC_ADD: if (cmd_idx == IW'(g)) begin
            b_q <= cmd_base;
            s_q <= cmd_size;
          end else if (cmd_idx < IW'(g)) begin
            b_q <= dn_b;
            s_q <= dn_s;
          end
          default: ;
        endcase
      end
    end

    assign base_v[g] = b_q;
    assign size_v[g] = s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (cmd == TC_ADD) count <= count + 1'b1;
    else if (cmd == TC_DROP) count <= count - 1'b1;
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    if (rd_idx < IW'(N_ENTRIES)) begin
      rd_base = base_v[rd_idx[AIW-1:0]];
      rd_size = size_v[rd_idx[AIW-1:0]];
    end
  end

  // R5
  drop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == TC_DROP |=> count == $past(count) - 1'b1);
  // R5
  drop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == TC_DROP |-> cmd_idx < count);
  // R7
  add_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == TC_ADD |-> count < IW'(N_ENTRIES));
  // R7
  add_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == TC_ADD |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/fl_pick.sv
module fl_pick
  import fl_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  fit_e              pol,
  input  logic [SIZE_W-1:0] need,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic              have,
  input  logic [SIZE_W-1:0] have_size,
  output logic              take,
  output logic              stop
);
  logic fits;

  always_comb begin
    fits = ent_size >= need;
    stop = 1'b0;
    case (pol)
      FIT_BEST:  take = fits && (!have || ent_size < have_size);
      FIT_WORST: take = fits && (!have || ent_size > have_size);
      default: begin
        take = fits && !have;
        stop = fits;
      end
    endcase
  end
endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 16,
  localparam int IW       = $clog2(N_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [1:0]        req_policy,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [IW-1:0]     tbl_count,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [SIZE_W-1:0] tbl_size,
  output logic [IW-1:0]     rd_idx,
  output tcmd_e             cmd,
  output logic [IW-1:0]     cmd_idx,
  output logic [ADDR_W-1:0] cmd_base,
  output logic [SIZE_W-1:0] cmd_size,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_base
);
  cstate_e           state_q;
  logic              op_q;
  fit_e              pol_q;
  logic [SIZE_W-1:0] need_q;
  logic [ADDR_W-1:0] fbase_q;
  logic [IW-1:0]     idx_q;
  logic              have_q;
  logic [IW-1:0]     pick_idx_q;
  logic [SIZE_W-1:0] pick_size_q;
  logic [ADDR_W-1:0] pick_base_q;
  rstat_e            stat_q;
  logic              done_q;
  rstat_e            rstat_q;
  logic [ADDR_W-1:0] rbase_q;

  logic take, stop, at_end, accept;

  fl_pick #(.SIZE_W(SIZE_W)) u_pick (
    .pol      (pol_q),
    .need     (need_q),
    .ent_size (tbl_size),
    .have     (have_q),
    .have_size(pick_size_q),
    .take     (take),
    .stop     (stop)
  );

  assign req_ready = (state_q == CS_IDLE);
  assign accept    = req_valid && req_ready;
  assign at_end    = (idx_q == tbl_count);
  assign rd_idx    = idx_q;

  always_comb begin
    cmd      = TC_NONE;
    cmd_idx  = pick_idx_q;
    cmd_base = fbase_q;
    cmd_size = need_q;
    if (state_q == CS_FIN && stat_q == RS_OK) begin
      if (op_q) cmd = TC_ADD;
      else if (have_q) cmd = (pick_size_q == need_q) ? TC_DROP : TC_TRIM;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CS_IDLE;
      op_q        <= 1'b0;
      pol_q       <= FIT_FIRST;
      need_q      <= '0;
      fbase_q     <= '0;
      idx_q       <= '0;
      have_q      <= 1'b0;
      pick_idx_q  <= '0;
      pick_size_q <= '0;
      pick_base_q <= '0;
      stat_q      <= RS_OK;
      done_q      <= 1'b0;
      rstat_q     <= RS_OK;
      rbase_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        CS_IDLE: if (accept) begin
          op_q    <= req_op;
          pol_q   <= fit_e'(req_policy);
          need_q  <= req_size;
          fbase_q <= req_base;
          idx_q   <= '0;
          have_q  <= 1'b0;
          if (req_size == '0) begin
            stat_q  <= RS_BADSZ;
            state_q <= CS_FIN;
          end else if (req_op && tbl_count == IW'(N_ENTRIES)) begin
            stat_q  <= RS_FULL;
            state_q <= CS_FIN;
          end else begin
            stat_q  <= RS_OK;
            state_q <= CS_SCAN;
          end
        end
        CS_SCAN: begin
          if (at_end) begin
            if (op_q) pick_idx_q <= idx_q;
            state_q <= CS_FIN;
          end else if (!op_q) begin
            if (take) begin
              have_q      <= 1'b1;
              pick_idx_q  <= idx_q;
              pick_size_q <= tbl_size;
              pick_base_q <= tbl_base;
            end
            if (stop) state_q <= CS_FIN;
            else idx_q <= idx_q + 1'b1;
          end else if (tbl_base > fbase_q) begin
            pick_idx_q <= idx_q;
            state_q    <= CS_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        CS_FIN: begin
          done_q  <= 1'b1;
          state_q <= CS_IDLE;
          if (stat_q != RS_OK) begin
            rstat_q <= stat_q;
            rbase_q <= '0;
          end else if (!op_q && !have_q) begin
            rstat_q <= RS_NOFIT;
            rbase_q <= '0;
          end else begin
            rstat_q <= RS_OK;
            rbase_q <= op_q ? '0 : pick_base_q;
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign rsp_done   = done_q;
  assign rsp_status = rstat_q;
  assign rsp_base   = rbase_q;

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R4
  trim_smaller_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == TC_TRIM |-> pick_size_q > need_q);
endmodule

// File: rtl/fl_alloc.sv
module fl_alloc
  import fl_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [1:0]        req_policy,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_base,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [ADDR_W-1:0] rsp_base
);
  localparam int IW = $clog2(N_ENTRIES + 1);

  tcmd_e             cmd;
  logic [IW-1:0]     cmd_idx, rd_idx, tbl_count;
  logic [ADDR_W-1:0] cmd_base, tbl_base;
  logic [SIZE_W-1:0] cmd_size, tbl_size;

  fl_table #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .cmd_idx (cmd_idx),
    .cmd_base(cmd_base),
    .cmd_size(cmd_size),
    .rd_idx  (rd_idx),
    .rd_base (tbl_base),
    .rd_size (tbl_size),
    .count   (tbl_count)
  );

  fl_ctrl #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_policy(req_policy),
    .req_size  (req_size),
    .req_base  (req_base),
    .tbl_count (tbl_count),
    .tbl_base  (tbl_base),
    .tbl_size  (tbl_size),
    .rd_idx    (rd_idx),
    .cmd       (cmd),
    .cmd_idx   (cmd_idx),
    .cmd_base  (cmd_base),
    .cmd_size  (cmd_size),
    .rsp_done  (rsp_done),
    .rsp_status(rsp_status),
    .rsp_base  (rsp_base)
  );

  // R6
  nofit_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status == RS_NOFIT) |-> $stable(tbl_count) && rsp_base == '0);
  // R8
  badsize_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status == RS_BADSZ) |-> $stable(tbl_count));
  // R9
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
  // R7
  full_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status == RS_FULL) |-> tbl_count == IW'(N_ENTRIES));
endmodule

// File: tb/fl_alloc_bench.sv
`timescale 1ns/1ps
module fl_alloc_bench;
  localparam int N  = 4;
  localparam int AW = 10;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [1:0]    req_policy = 2'd0;
  logic [SW-1:0] req_size = '0;
  logic [AW-1:0] req_base = '0;
  logic          rsp_done;
  logic [1:0]    rsp_status;
  logic [AW-1:0] rsp_base;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [AW-1:0] m_base [N];
  logic [SW-1:0] m_size [N];
  int            m_cnt = 0;

  logic [1:0]    got_st;
  logic [AW-1:0] got_b;

  always #2 clk = ~clk;

  fl_alloc #(.N_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) u_fl_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_policy(req_policy), .req_size(req_size),
    .req_base(req_base), .rsp_done(rsp_done), .rsp_status(rsp_status),
    .rsp_base(rsp_base)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Reference model: ordered list with exact-size split
  task automatic model(input logic op, input logic [1:0] pol, input logic [SW-1:0] sz,
                       input logic [AW-1:0] bs, output logic [1:0] st, output logic [AW-1:0] ob);
    int sel;
    int pos;
    ob = '0;
    if (sz == 0) st = 2'd3;
    else if (op) begin
      if (m_cnt == N) st = 2'd2;
      else begin
        pos = m_cnt;
        for (int i = m_cnt - 1; i >= 0; i--) if (m_base[i] > bs) pos = i;
        for (int i = m_cnt; i > pos; i--) begin
          m_base[i] = m_base[i-1];
          m_size[i] = m_size[i-1];
        end
        m_base[pos] = bs;
        m_size[pos] = sz;
        m_cnt++;
        st = 2'd0;
      end
    end else begin
      sel = -1;
      for (int i = 0; i < m_cnt; i++) if (m_size[i] >= sz) begin
        case (pol)
          2'd1: if (sel < 0 || m_size[i] < m_size[sel]) sel = i;
          2'd2: if (sel < 0 || m_size[i] > m_size[sel]) sel = i;
          default: if (sel < 0) sel = i;
        endcase
      end
      if (sel < 0) st = 2'd1;
      else begin
        st = 2'd0;
        ob = m_base[sel];
        if (m_size[sel] == sz) begin
          for (int i = sel; i < m_cnt - 1; i++) begin
            m_base[i] = m_base[i+1];
            m_size[i] = m_size[i+1];
          end
          m_cnt--;
        end else begin
          m_base[sel] = m_base[sel] + AW'(sz);
          m_size[sel] = m_size[sel] - sz;
        end
      end
    end
  endtask

  task automatic drive(input logic op, input logic [1:0] pol, input int sz, input int bs);
    req_valid  = 1'b1;
    req_op     = op;
    req_policy = pol;
    req_size   = SW'(sz);
    req_base   = AW'(bs);
  endtask

  task automatic wait_done(input string tag, input logic [1:0] est, input logic [AW-1:0] eb);
    while (!rsp_done) @(negedge clk);
    got_st = rsp_status;
    got_b  = rsp_base;
    chk(got_st == est, tag, int'(got_st), int'(est));
    chk(got_b == eb, tag, int'(got_b), int'(eb));
  endtask

  task automatic run_op(input logic op, input logic [1:0] pol, input int sz, input int bs,
                        input string tag);
    logic [1:0]    est;
    logic [AW-1:0] eb;
    model(op, pol, SW'(sz), AW'(bs), est, eb);
    @(negedge clk);
    drive(op, pol, sz, bs);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", int'(req_ready), 0);
    wait_done(tag, est, eb);
  endtask

  task automatic expect_lit(input string tag, input int st, input int b);
    chk(int'(got_st) == st, tag, int'(got_st), st);
    chk(int'(got_b) == b, tag, int'(got_b), b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0]    est;
    logic [AW-1:0] eb;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10", int'(req_ready), 1);
    chk(rsp_done == 1'b0, "R10", int'(rsp_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", int'(req_ready), 1);

    run_op(1'b0, 2'd0, 5, 0, "R10"); expect_lit("R10", 1, 0);

    // first-fit fragmentation run; R7 inserts out of order
    run_op(1'b1, 2'd0, 50, 100, "R7");
    run_op(1'b1, 2'd0, 100, 600, "R7");
    run_op(1'b1, 2'd0, 155, 300, "R7");
    run_op(1'b0, 2'd0, 90, 0, "R1");  expect_lit("R1", 0, 300);
    run_op(1'b0, 2'd0, 100, 0, "R5"); expect_lit("R5", 0, 600);
    run_op(1'b0, 2'd0, 60, 0, "R4");  expect_lit("R4", 0, 390);
    run_op(1'b0, 2'd2, 50, 0, "R3");  expect_lit("R3", 0, 100);
    run_op(1'b0, 2'd3, 5, 0, "R4");   expect_lit("R4", 0, 450);
    run_op(1'b0, 2'd0, 1, 0, "R5");   expect_lit("R5", 1, 0);

    // best-fit run leaves 50,55,10 and cannot serve 60
    run_op(1'b1, 2'd0, 50, 100, "R7");
    run_op(1'b1, 2'd0, 155, 300, "R7");
    run_op(1'b1, 2'd0, 100, 600, "R7");
    run_op(1'b0, 2'd1, 90, 0, "R2");  expect_lit("R2", 0, 600);
    run_op(1'b0, 2'd1, 100, 0, "R2"); expect_lit("R2", 0, 300);
    run_op(1'b0, 2'd1, 60, 0, "R6");  expect_lit("R6", 1, 0);
    run_op(1'b0, 2'd1, 10, 0, "R6");  expect_lit("R6", 0, 690);
    run_op(1'b0, 2'd1, 50, 0, "R2");  expect_lit("R2", 0, 100);
    run_op(1'b0, 2'd1, 55, 0, "R2");  expect_lit("R2", 0, 400);

    // ties go to the lower address
    run_op(1'b1, 2'd0, 30, 200, "R7");
    run_op(1'b1, 2'd0, 30, 50, "R7");
    run_op(1'b1, 2'd0, 30, 500, "R7");
    run_op(1'b0, 2'd2, 20, 0, "R3");  expect_lit("R3", 0, 50);
    run_op(1'b0, 2'd1, 30, 0, "R2");  expect_lit("R2", 0, 200);

    // table full, zero size
    run_op(1'b1, 2'd0, 5, 700, "R7");
    run_op(1'b1, 2'd0, 5, 800, "R7");
    run_op(1'b1, 2'd0, 5, 900, "R7"); expect_lit("R7", 2, 0);
    run_op(1'b0, 2'd0, 0, 0, "R8");   expect_lit("R8", 3, 0);
    run_op(1'b1, 2'd0, 0, 10, "R8");  expect_lit("R8", 3, 0);
    run_op(1'b0, 2'd2, 30, 0, "R8");  expect_lit("R8", 0, 500);

    // R9 back-to-back: next request accepted in the done cycle
    model(1'b1, 2'd0, SW'(12), AW'(20), est, eb);
    @(negedge clk);
    drive(1'b1, 2'd0, 12, 20);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wait_done("R9", est, eb);
    chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
    model(1'b0, 2'd0, SW'(12), AW'(0), est, eb);
    drive(1'b0, 2'd0, 12, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", int'(req_ready), 0);
    wait_done("R9", est, eb);
    chk(int'(got_b) == 20, "R9", int'(got_b), 20);

    // mixed sweep against the model
    for (int k = 0; k < 400; k++) begin
      logic op;
      logic [1:0] pol;
      int sz;
      string tag;
      op  = ($urandom_range(0, 99) < 45);
      pol = 2'($urandom_range(0, 3));
      sz  = ($urandom_range(0, 15) == 0) ? 0 : int'($urandom_range(1, 70));
      if (sz == 0) tag = "R8";
      else if (op) tag = "R7";
      else if (pol == 2'd1) tag = "R2";
      else if (pol == 2'd2) tag = "R3";
      else tag = "R1";
      run_op(op, pol, sz, int'($urandom_range(0, 1023)), tag);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule